// File: doc/BRIEF.md
# Execution Slice Budget Controller

This block decides how long a processor core keeps executing within one timeslice. A start pulse loads a cycle budget. Each retired instruction reports its cycle cost, and that cost is taken off the remaining budget. The stop decision is made only at instruction boundaries, so the core always finishes at least one instruction. It may overrun the request by at most the cost of the last instruction. Interrupt entry cost is also charged to the slice. A release command ends the slice at once.

Beside the budget, the block keeps an elapsed-cycle odometer that runs across slices. Software reads it and can choose to zero it on the same read. Repeating block-transfer instructions report every iteration as a separate retire. The budget can therefore stop them between iterations, and a pending flag tells the core to re-enter the unfinished instruction in the next slice.

Top module: `slice_ctrl`

## Requirements
- R1: After reset, run_o, stop_o and rep_pending_o are 0, and remaining_o, elapsed_o and rd_data_o are all zero.
- R2: A start_i pulse loads remaining_o with budget_i (zero-extended) and sets run_o=1 and stop_o=0 on the next cycle. Start has priority over release and retire in the same cycle.
- R3: While run_o=1, a retire_i pulse subtracts retire_cyc_i from remaining_o. remaining_o is signed two's complement, so an overrun reads as a negative value. The slice continues while the result is zero or greater.
- R4: While run_o=1, a retire that leaves remaining_o below zero ends the slice on the next cycle (run_o=0, stop_o=1). stop_o then holds until the next start. With a budget of zero, exactly one instruction retires.
- R5: A retire with retire_ei_i=1 never ends the slice, whatever the remaining budget. The instruction after it is therefore completed, and the next retire is judged normally.
- R6: release_i (without start) sets remaining_o to zero on the next cycle and ends a running slice (run_o=0, stop_o=1).
- R7: While run_o=0, retire and interrupt charges leave remaining_o, run_o and stop_o unchanged.
- R8: In every cycle, elapsed_o grows by retire_cyc_i when retire_i=1 plus irq_cyc_i when irq_i=1, whether or not a slice is running. It wraps modulo 2^32.
- R9: rd_i=1 sets rd_data_o to the elapsed value including that cycle's charges. If rd_clr_i=1 as well, elapsed_o becomes zero on the next cycle; otherwise it keeps counting.
- R10: While run_o=1, irq_i subtracts irq_cyc_i from remaining_o in the same way as a retire, but it never ends the slice by itself.
- R11: rep_pending_o becomes 1 after a retire with retire_rep_i=1 (a non-final iteration of a block-repeat instruction). It becomes 0 after a retire with retire_rep_i=0, and it is unaffected by start and release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new slice |
| budget_i | input | 31 | Cycle budget for the new slice |
| release_i | input | 1 | Give up the rest of the slice |
| retire_i | input | 1 | One instruction (or block-repeat iteration) retired |
| retire_cyc_i | input | 5 | Cycle cost of the retired unit |
| retire_ei_i | input | 1 | Retired unit was the interrupt-enable instruction |
| retire_rep_i | input | 1 | Retired unit was a non-final block-repeat iteration |
| irq_i | input | 1 | Interrupt or NMI entry taken |
| irq_cyc_i | input | 5 | Cycle cost of the interrupt entry |
| rd_i | input | 1 | Read the elapsed counter |
| rd_clr_i | input | 1 | Zero the elapsed counter with this read |
| run_o | output | 1 | Slice in progress, core may start instructions |
| stop_o | output | 1 | Slice finished, held until next start |
| remaining_o | output | 32 | Signed remaining budget |
| elapsed_o | output | 32 | Live elapsed-cycle odometer |
| rd_data_o | output | 32 | Value captured by the last read |
| rep_pending_o | output | 1 | A block-repeat instruction is unfinished |

## Verification
The assertions check, on every cycle, that run and stop are never high together and that stop holds until a start. They also check that start and release take effect on the next cycle, that an interrupt-enable retire never ends a slice, and that a clearing read leaves the odometer at zero. The bench's scenarios show the arithmetic: the exact signed remaining value after chains of retires and interrupt charges, the overrun limit for a zero budget, the one-instruction grace after the interrupt-enable instruction, and that no charge is lost when a read-with-clear meets a retire. A reference model in the bench compares every output on every cycle of a seeded random run.

// File: rtl/slice_pkg.sv
package slice_pkg;
   // Default geometry for the slice controller family.
   localparam int unsigned DEF_REM_W  = 32;  // signed remaining budget
   localparam int unsigned DEF_CYC_W  = 5;   // longest instruction is 24 cycles
   localparam int unsigned DEF_ELAP_W = 32;  // odometer width

   // Overflow policy for the elapsed odometer.
   typedef enum logic [0:0] {
      ODO_WRAP     = 1'b0,
      ODO_SATURATE = 1'b1
   } odo_mode_e;
endpackage

// File: rtl/slice_budget.sv
module slice_budget #(
   parameter int unsigned REM_W = slice_pkg::DEF_REM_W,
   parameter int unsigned CYC_W = slice_pkg::DEF_CYC_W,
   localparam int unsigned BUD_W = REM_W - 1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    start_i,
   input  logic [BUD_W-1:0]        budget_i,
   input  logic                    release_i,
   input  logic                    retire_i,
   input  logic [CYC_W-1:0]        retire_cyc_i,
   input  logic                    retire_ei_i,
   input  logic                    irq_i,
   input  logic [CYC_W-1:0]        irq_cyc_i,
   output logic                    run_o,
   output logic                    stop_o,
   output logic signed [REM_W-1:0] remaining_o
);
   localparam int unsigned PAD_W = REM_W - CYC_W;

   initial begin
      assert (REM_W > CYC_W + 1) else $error("slice_budget: REM_W too narrow for CYC_W");
   end

   logic signed [REM_W-1:0] rem_q, rem_dec;
   logic signed [REM_W-1:0] ret_cost, irq_cost;
   logic                    run_q, stop_q;
   logic                    overrun;

   assign ret_cost = retire_i ? $signed({{PAD_W{1'b0}}, retire_cyc_i}) : '0;
   assign irq_cost = irq_i    ? $signed({{PAD_W{1'b0}}, irq_cyc_i})    : '0;
   assign rem_dec  = rem_q - ret_cost - irq_cost;
   // Only an ordinary retire may end a slice; the EI grace lets one more run.
   assign overrun  = retire_i && !retire_ei_i && rem_dec[REM_W-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rem_q  <= '0;
         run_q  <= 1'b0;
         stop_q <= 1'b0;
      end else if (start_i) begin
         rem_q  <= $signed({1'b0, budget_i});
         run_q  <= 1'b1;
         stop_q <= 1'b0;
      end else if (release_i) begin
         rem_q <= '0;
         if (run_q) begin
            run_q  <= 1'b0;
            stop_q <= 1'b1;
         end
      end else if (run_q) begin
         rem_q <= rem_dec;
         if (overrun) begin
            run_q  <= 1'b0;
            stop_q <= 1'b1;
         end
      end
   end

   assign run_o       = run_q;
   assign stop_o      = stop_q;
   assign remaining_o = rem_q;

   p_run_stop_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(run_q && stop_q));
   p_stop_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_q && !start_i) |=> stop_q);
   p_start_loads_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (run_q && !stop_q && rem_q == $signed({1'b0, $past(budget_i)})));
   p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (release_i && !start_i) |=> (!run_q && rem_q == 0));
   p_ei_grace_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && retire_i && retire_ei_i && !release_i) |=> run_q);
   p_idle_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !start_i && !release_i) |=> ($stable(rem_q) && !run_q));
endmodule

// File: rtl/slice_odometer.sv
module slice_odometer #(
   parameter int unsigned        CYC_W  = slice_pkg::DEF_CYC_W,
   parameter int unsigned        ELAP_W = slice_pkg::DEF_ELAP_W,
   parameter slice_pkg::odo_mode_e MODE = slice_pkg::ODO_WRAP
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              retire_i,
   input  logic [CYC_W-1:0]  retire_cyc_i,
   input  logic              irq_i,
   input  logic [CYC_W-1:0]  irq_cyc_i,
   input  logic              rd_i,
   input  logic              rd_clr_i,
   output logic [ELAP_W-1:0] elapsed_o,
   output logic [ELAP_W-1:0] rd_data_o
);
   localparam int unsigned PAD_W = ELAP_W - CYC_W;

   initial begin
      assert (ELAP_W > CYC_W + 1) else $error("slice_odometer: ELAP_W too narrow");
   end

   logic [ELAP_W-1:0] elap_q, rd_q, add, sum;

   assign add = (retire_i ? {{PAD_W{1'b0}}, retire_cyc_i} : '0)
              + (irq_i    ? {{PAD_W{1'b0}}, irq_cyc_i}    : '0);

   generate
      if (MODE == slice_pkg::ODO_SATURATE) begin : g_sat
         logic [ELAP_W:0] wide;
         assign wide = {1'b0, elap_q} + {1'b0, add};
         assign sum  = wide[ELAP_W] ? {ELAP_W{1'b1}} : wide[ELAP_W-1:0];
      end else begin : g_wrap
         assign sum = elap_q + add;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         elap_q <= '0;
         rd_q   <= '0;
      end else begin
         // A clearing read returns this cycle's charges so nothing is lost.
         if (rd_i) rd_q <= sum;
         elap_q <= (rd_i && rd_clr_i) ? '0 : sum;
      end
   end

   assign elapsed_o = elap_q;
   assign rd_data_o = rd_q;

   p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && rd_clr_i) |=> (elap_q == '0));
   p_no_read_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_i |=> $stable(rd_q));
   p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!retire_i && !irq_i && !rd_i) |=> $stable(elap_q));
endmodule

// File: rtl/slice_rep_track.sv
module slice_rep_track (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic retire_i,
   input  logic retire_rep_i,
   output logic rep_pending_o
);
   logic pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q <= 1'b0;
      else if (retire_i) pend_q <= retire_rep_i;
   end

   assign rep_pending_o = pend_q;

   p_rep_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (retire_i && retire_rep_i) |=> pend_q);
   p_rep_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !retire_i |=> $stable(pend_q));
endmodule

// File: rtl/slice_ctrl.sv
module slice_ctrl #(
   parameter int unsigned          REM_W  = slice_pkg::DEF_REM_W,
   parameter int unsigned          CYC_W  = slice_pkg::DEF_CYC_W,
   parameter int unsigned          ELAP_W = slice_pkg::DEF_ELAP_W,
   parameter slice_pkg::odo_mode_e ODO    = slice_pkg::ODO_WRAP,
   localparam int unsigned         BUD_W  = REM_W - 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [BUD_W-1:0]  budget_i,
   input  logic              release_i,
   input  logic              retire_i,
   input  logic [CYC_W-1:0]  retire_cyc_i,
   input  logic              retire_ei_i,
   input  logic              retire_rep_i,
   input  logic              irq_i,
   input  logic [CYC_W-1:0]  irq_cyc_i,
   input  logic              rd_i,
   input  logic              rd_clr_i,
   output logic              run_o,
   output logic              stop_o,
   output logic [REM_W-1:0]  remaining_o,
   output logic [ELAP_W-1:0] elapsed_o,
   output logic [ELAP_W-1:0] rd_data_o,
   output logic              rep_pending_o
);
   logic signed [REM_W-1:0] rem_s;

   slice_budget #(.REM_W(REM_W), .CYC_W(CYC_W)) u_budget (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (start_i),
      .budget_i     (budget_i),
      .release_i    (release_i),
      .retire_i     (retire_i),
      .retire_cyc_i (retire_cyc_i),
      .retire_ei_i  (retire_ei_i),
      .irq_i        (irq_i),
      .irq_cyc_i    (irq_cyc_i),
      .run_o        (run_o),
      .stop_o       (stop_o),
      .remaining_o  (rem_s)
   );

   assign remaining_o = rem_s;

   slice_odometer #(.CYC_W(CYC_W), .ELAP_W(ELAP_W), .MODE(ODO)) u_odo (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .retire_i     (retire_i),
      .retire_cyc_i (retire_cyc_i),
      .irq_i        (irq_i),
      .irq_cyc_i    (irq_cyc_i),
      .rd_i         (rd_i),
      .rd_clr_i     (rd_clr_i),
      .elapsed_o    (elapsed_o),
      .rd_data_o    (rd_data_o)
   );

   slice_rep_track u_rep (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .retire_i      (retire_i),
      .retire_rep_i  (retire_rep_i),
      .rep_pending_o (rep_pending_o)
   );
endmodule

// File: tb/slice_ctrl_tb.sv
module slice_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 0, release_c = 0, retire = 0, ei = 0, rep = 0, irq = 0, rd = 0, clr = 0;
   logic [30:0] budget = '0;
   logic [4:0]  rcyc = '0, icyc = '0;
   logic        run, stop, rep_pend;
   logic [31:0] rem, elap, rdd;

   int   n_chk = 0, n_bad = 0;
   bit   done = 0;

   // reference state
   int          m_rem = 0;
   bit          m_run = 0, m_stop = 0, m_rep = 0;
   logic [31:0] m_elap = '0, m_rdd = '0;

   always #5 clk = ~clk;

   slice_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .budget_i(budget),
      .release_i(release_c), .retire_i(retire), .retire_cyc_i(rcyc),
      .retire_ei_i(ei), .retire_rep_i(rep), .irq_i(irq), .irq_cyc_i(icyc),
      .rd_i(rd), .rd_clr_i(clr), .run_o(run), .stop_o(stop),
      .remaining_o(rem), .elapsed_o(elap), .rd_data_o(rdd),
      .rep_pending_o(rep_pend)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
      end
   endtask

   task automatic chk_all();
      chk("R4 run", {31'd0, run}, {31'd0, m_run});
      chk("R4 stop", {31'd0, stop}, {31'd0, m_stop});
      chk("R3 remaining", rem, m_rem);
      chk("R8 elapsed", elap, m_elap);
      chk("R9 rd_data", rdd, m_rdd);
      chk("R11 rep_pending", {31'd0, rep_pend}, {31'd0, m_rep});
   endtask

   // Next-state of the reference model from the inputs now applied.
   task automatic model_step();
      int          dec;
      logic [31:0] sum;
      sum = m_elap + (retire ? {27'd0, rcyc} : 32'd0) + (irq ? {27'd0, icyc} : 32'd0);
      if (rd) m_rdd = sum;
      m_elap = (rd && clr) ? 32'd0 : sum;
      if (retire) m_rep = rep;
      dec = m_rem - (retire ? int'(rcyc) : 0) - (irq ? int'(icyc) : 0);
      if (start) begin
         m_rem = int'(budget); m_run = 1; m_stop = 0;
      end else if (release_c) begin
         m_rem = 0;
         if (m_run) begin m_run = 0; m_stop = 1; end
      end else if (m_run) begin
         m_rem = dec;
         if (retire && !ei && dec < 0) begin m_run = 0; m_stop = 1; end
      end
   endtask

   task automatic idle_in();
      start = 0; release_c = 0; retire = 0; ei = 0; rep = 0; irq = 0; rd = 0; clr = 0;
   endtask

   // Apply current inputs for one cycle, then check at the next falling edge.
   task automatic cyc();
      model_step();
      @(negedge clk);
      chk_all();
      idle_in();
   endtask

   task automatic do_start(input int b);
      idle_in(); start = 1; budget = 31'(b); cyc();
   endtask

   task automatic do_retire(input int c, input bit e, input bit r);
      idle_in(); retire = 1; rcyc = 5'(c); ei = e; rep = r; cyc();
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk_all();                             // R1 reset state
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 run after reset", {31'd0, run}, 32'd0);

      // R4: zero budget still retires one instruction and then stops
      do_start(0);
      chk("R2 start run", {31'd0, run}, 32'd1);
      do_retire(4, 0, 0);
      chk("R4 zero budget stop", {31'd0, stop}, 32'd1);
      chk("R4 overrun value", rem, 32'hFFFF_FFFC);

      // R7: retire while stopped leaves remaining alone
      do_retire(7, 0, 0);
      chk("R7 idle remaining", rem, 32'hFFFF_FFFC);
      chk("R7 idle run", {31'd0, run}, 32'd0);

      // R3: exact zero keeps running
      do_start(10);
      do_retire(10, 0, 0);
      chk("R3 zero keeps run", {31'd0, run}, 32'd1);

      // R5: EI grace, then next instruction judged
      do_start(5);
      do_retire(10, 1, 0);
      chk("R5 ei grace", {31'd0, run}, 32'd1);
      do_retire(4, 0, 0);
      chk("R5 after ei stops", {31'd0, stop}, 32'd1);
      chk("R5 remaining", rem, 32'hFFFF_FFF7);

      // R10: interrupt charge reduces budget without stopping
      do_start(3);
      idle_in(); irq = 1; icyc = 5'd13; cyc();
      chk("R10 irq no stop", {31'd0, run}, 32'd1);
      chk("R10 irq charge", rem, 32'hFFFF_FFF6);

      // R6: release with a retire in the same cycle
      idle_in(); release_c = 1; retire = 1; rcyc = 5'd6; cyc();
      chk("R6 release remaining", rem, 32'd0);
      chk("R6 release stop", {31'd0, stop}, 32'd1);

      // R9: read with clear plus same-cycle retire
      idle_in(); rd = 1; clr = 1; retire = 1; rcyc = 5'd9; cyc();
      chk("R9 clear zero", elap, 32'd0);
      do_retire(5, 0, 1);
      chk("R11 rep set", {31'd0, rep_pend}, 32'd1);
      chk("R8 elapsed grows", elap, 32'd5);
      idle_in(); rd = 1; cyc();
      chk("R9 read no clear", rdd, 32'd5);
      chk("R9 still counting", elap, 32'd5);

      // R2: start beats release
      idle_in(); start = 1; budget = 31'd77; release_c = 1; cyc();
      chk("R2 start priority", rem, 32'd77);

      // seeded random traffic against the model
      for (int i = 0; i < 4000; i++) begin
         int p;
         idle_in();
         p = int'($urandom_range(0, 99));
         start     = (p < 4);
         budget    = 31'($urandom_range(0, 120));
         release_c = ($urandom_range(0, 99) < 2);
         retire    = ($urandom_range(0, 99) < 55);
         rcyc      = 5'($urandom_range(4, 24));
         ei        = ($urandom_range(0, 99) < 8);
         rep       = ($urandom_range(0, 99) < 20);
         irq       = ($urandom_range(0, 99) < 5);
         icyc      = 5'($urandom_range(11, 19));
         rd        = ($urandom_range(0, 99) < 10);
         clr       = ($urandom_range(0, 1) == 1);
         cyc();
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule